// File: doc/BRIEF.md
# Swizzled Four-Lane Register-File Adder

This block holds thirty-two wide registers. Each register is split into four 24-bit lanes, named a, b, c and d. Lane a sits in the lowest bits. The block also contains an adder that works on each lane separately. An add operation names two source registers, one lane swizzle for each operand, a destination register and a lane mask. Each swizzle builds a temporary four-lane value. Each of its lanes may copy any lane of its source. The two temporaries are added lane by lane. Only the lanes enabled in the mask are written back. The other lanes of the destination keep their old contents.

A lane may hold a plain 24-bit integer or a signed value with 7 integer bits and 16 fraction bits. Both are added by the same wrapping binary adder. A separate load port writes a whole register, and a combinational read port shows any register. The add is issued with a valid strobe and commits at the next rising clock edge. Reset is synchronous and active low.

Top module: `swz_lane_adder`

## Requirements
- R1: While `rst_n` is low at a rising edge, every register is cleared to zero.
- R2: A load with `ld_valid` high writes all 96 bits of `ld_data` into register `ld_addr` at the next edge. This holds unless an add targets the same register in that cycle.
- R3: A swizzle is four 2-bit selectors. Bits [2k+1:2k] choose the source lane for temporary lane k, with a=0, b=1, c=2 and d=3. The source lanes and temporary lanes are packed with lane a at bits [23:0], lane b at [47:24], lane c at [71:48] and lane d at [95:72].
- R4: Temporary lane k of the result is the sum of lane k of both temporaries, taken modulo 2^24. No carry passes between lanes.
- R5: Mask bit k (bit 0 is lane a, bit 3 is lane d) enables the write of lane k. Lanes whose mask bit is clear keep their previous value.
- R6: An add whose mask is zero leaves the destination register unchanged.
- R7: When the destination is also a source, the add uses the source values from before the write.
- R8: When an add and a load target the same register in the same cycle, the load has no effect on any lane of that register. A load to a different register in the same cycle still completes.
- R9: While `op_valid` is low, the add inputs have no effect on any register.
- R10: `rd_data` shows register `rd_addr` combinationally, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Add strobe |
| op_src0 | input | 5 | First source register |
| op_src1 | input | 5 | Second source register |
| op_swz0 | input | 8 | Swizzle for first operand |
| op_swz1 | input | 8 | Swizzle for second operand |
| op_dst | input | 5 | Destination register |
| op_mask | input | 4 | Destination lane mask |
| ld_valid | input | 1 | Direct load strobe |
| ld_addr | input | 5 | Load target register |
| ld_data | input | 96 | Load data |
| rd_addr | input | 5 | Observe register index |
| rd_data | output | 96 | Observed register contents |

## Verification
The assertions assume that `rd_addr` is a value the bench holds steady around each edge. With that, a comparison between the current and previous cycle really refers to one register. The lane-hold and no-write properties depend on this. The stimulus changes inputs only on falling edges, and it keeps `rd_addr` fixed across each operation. Add and load strobes last exactly one cycle, so every commit can be traced to a single request.

// File: rtl/swl_pkg.sv
// Shared defaults for the swizzled lane adder.
// Assumes: lanes are packed with lane 0 (a) in the low bits.
package swl_pkg;
    localparam int unsigned DEF_LANE_W = 24;
    localparam int unsigned DEF_LANES  = 4;
    localparam int unsigned DEF_REGS   = 32;
endpackage

// File: rtl/swl_swizzle.sv
// Builds a temporary vector where each lane copies a selected source lane.
// Assumes: SEL_W bits per selector are enough to index LANES lanes.
module swl_swizzle #(
    parameter int unsigned LANE_W = swl_pkg::DEF_LANE_W,
    parameter int unsigned LANES  = swl_pkg::DEF_LANES,
    parameter int unsigned SEL_W  = $clog2(LANES)
) (
    input  logic [LANES*LANE_W-1:0] src,
    input  logic [LANES*SEL_W-1:0]  sel,
    output logic [LANES*LANE_W-1:0] tmp
);
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [SEL_W-1:0] pick;
        assign pick = sel[k*SEL_W +: SEL_W];
        // Route the chosen source lane to temporary lane k.
        always_comb begin
            tmp[k*LANE_W +: LANE_W] = src[int'(pick)*LANE_W +: LANE_W];
        end
    end
endmodule

// File: rtl/swl_adder.sv
// Lane-wise wrapping adder; no carry crosses a lane boundary.
// Assumes: both operands use the same lane packing.
module swl_adder #(
    parameter int unsigned LANE_W = swl_pkg::DEF_LANE_W,
    parameter int unsigned LANES  = swl_pkg::DEF_LANES
) (
    input  logic [LANES*LANE_W-1:0] opa,
    input  logic [LANES*LANE_W-1:0] opb,
    output logic [LANES*LANE_W-1:0] sum
);
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        // Independent modulo-2^LANE_W sum for lane k.
        assign sum[k*LANE_W +: LANE_W] = opa[k*LANE_W +: LANE_W] + opb[k*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/swl_regfile.sv
// Register file with lane-granular storage, two operand read ports,
// one observe port, a masked add write port and a full-width load port.
// Assumes: the add port has priority over the load port per register.
module swl_regfile #(
    parameter int unsigned LANE_W = swl_pkg::DEF_LANE_W,
    parameter int unsigned LANES  = swl_pkg::DEF_LANES,
    parameter int unsigned DEPTH  = swl_pkg::DEF_REGS,
    parameter int unsigned AW     = $clog2(DEPTH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [AW-1:0]           ra0,
    input  logic [AW-1:0]           ra1,
    input  logic [AW-1:0]           rao,
    output logic [LANES*LANE_W-1:0] rd0,
    output logic [LANES*LANE_W-1:0] rd1,
    output logic [LANES*LANE_W-1:0] rdo,
    input  logic                    wa_en,
    input  logic [AW-1:0]           wa_addr,
    input  logic [LANES-1:0]        wa_mask,
    input  logic [LANES*LANE_W-1:0] wa_data,
    input  logic                    wl_en,
    input  logic [AW-1:0]           wl_addr,
    input  logic [LANES*LANE_W-1:0] wl_data
);
    logic [LANE_W-1:0] mem [DEPTH][LANES];

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        logic hit_add;
        logic hit_ld;
        assign hit_add = wa_en && (wa_addr == AW'(i));
        assign hit_ld  = wl_en && (wl_addr == AW'(i)) && !hit_add;
        for (genvar k = 0; k < LANES; k++) begin : g_lane
            // Update one lane: reset, masked add, or unblocked load.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    mem[i][k] <= '0;
                end else if (hit_add && wa_mask[k]) begin
                    mem[i][k] <= wa_data[k*LANE_W +: LANE_W];
                end else if (hit_ld) begin
                    mem[i][k] <= wl_data[k*LANE_W +: LANE_W];
                end
            end
        end
    end

    for (genvar k = 0; k < LANES; k++) begin : g_rd
        // Combinational lane reads for the three read ports.
        assign rd0[k*LANE_W +: LANE_W] = mem[ra0][k];
        assign rd1[k*LANE_W +: LANE_W] = mem[ra1][k];
        assign rdo[k*LANE_W +: LANE_W] = mem[rao][k];
    end
endmodule

// File: rtl/swz_lane_adder.sv
// Top: swizzled lane-wise add into a masked destination, plus load/observe.
// Assumes: operands are read before the edge that commits the result.
module swz_lane_adder #(
    parameter int unsigned LANE_W = swl_pkg::DEF_LANE_W,
    parameter int unsigned LANES  = swl_pkg::DEF_LANES,
    parameter int unsigned REGS   = swl_pkg::DEF_REGS,
    localparam int unsigned AW    = $clog2(REGS),
    localparam int unsigned SEL_W = $clog2(LANES),
    localparam int unsigned DW    = LANES * LANE_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   op_valid,
    input  logic [AW-1:0]          op_src0,
    input  logic [AW-1:0]          op_src1,
    input  logic [LANES*SEL_W-1:0] op_swz0,
    input  logic [LANES*SEL_W-1:0] op_swz1,
    input  logic [AW-1:0]          op_dst,
    input  logic [LANES-1:0]       op_mask,
    input  logic                   ld_valid,
    input  logic [AW-1:0]          ld_addr,
    input  logic [DW-1:0]          ld_data,
    input  logic [AW-1:0]          rd_addr,
    output logic [DW-1:0]          rd_data
);
    logic [DW-1:0] src0_q;
    logic [DW-1:0] src1_q;
    logic [DW-1:0] tmp0;
    logic [DW-1:0] tmp1;
    logic [DW-1:0] lane_sum;

    swl_regfile #(.LANE_W(LANE_W), .LANES(LANES), .DEPTH(REGS), .AW(AW)) i_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .ra0     (op_src0),
        .ra1     (op_src1),
        .rao     (rd_addr),
        .rd0     (src0_q),
        .rd1     (src1_q),
        .rdo     (rd_data),
        .wa_en   (op_valid),
        .wa_addr (op_dst),
        .wa_mask (op_mask),
        .wa_data (lane_sum),
        .wl_en   (ld_valid),
        .wl_addr (ld_addr),
        .wl_data (ld_data)
    );

    swl_swizzle #(.LANE_W(LANE_W), .LANES(LANES), .SEL_W(SEL_W)) i_swz0 (
        .src (src0_q),
        .sel (op_swz0),
        .tmp (tmp0)
    );

    swl_swizzle #(.LANE_W(LANE_W), .LANES(LANES), .SEL_W(SEL_W)) i_swz1 (
        .src (src1_q),
        .sel (op_swz1),
        .tmp (tmp1)
    );

    swl_adder #(.LANE_W(LANE_W), .LANES(LANES)) i_add (
        .opa (tmp0),
        .opb (tmp1),
        .sum (lane_sum)
    );
endmodule

// File: rtl/swl_checker.sv
// Port-level properties of the swizzled lane adder, bound to the top.
// Assumes: rd_addr is held steady by the driver around edges of interest.
module swl_checker #(
    parameter int unsigned LANE_W = 24,
    parameter int unsigned LANES  = 4,
    parameter int unsigned AW     = 5
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    op_valid,
    input logic [AW-1:0]           op_dst,
    input logic [LANES-1:0]        op_mask,
    input logic                    ld_valid,
    input logic [AW-1:0]           ld_addr,
    input logic [LANES*LANE_W-1:0] ld_data,
    input logic [AW-1:0]           rd_addr,
    input logic [LANES*LANE_W-1:0] rd_data
);
    // Registers read as zero right after reset is released.
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> rd_data == '0);

    // An unobstructed load shows up in full.
    assert_load_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ld_valid) && !($past(op_valid) && $past(op_dst) == $past(ld_addr))
         && rd_addr == $past(ld_addr))
        |-> rd_data == $past(ld_data));

    // With neither write strobe, the observed register is stable.
    assert_idle_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(op_valid) && !$past(ld_valid) && $stable(rd_addr))
        |-> $stable(rd_data));

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        // Unmasked destination lanes keep their previous value.
        assert_lane_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(op_valid) && !$past(op_mask[k])
             && $past(rd_addr) == $past(op_dst) && rd_addr == $past(op_dst))
            |-> rd_data[k*LANE_W +: LANE_W] == $past(rd_data[k*LANE_W +: LANE_W]));

        // A colliding load does not leak into unmasked lanes.
        assert_collide_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(op_valid) && $past(ld_valid) && $past(ld_addr) == $past(op_dst)
             && !$past(op_mask[k]) && $past(rd_addr) == $past(op_dst) && rd_addr == $past(op_dst))
            |-> rd_data[k*LANE_W +: LANE_W] == $past(rd_data[k*LANE_W +: LANE_W]));
    end
endmodule

bind swz_lane_adder swl_checker #(.LANE_W(LANE_W), .LANES(LANES), .AW(AW)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op_dst   (op_dst),
    .op_mask  (op_mask),
    .ld_valid (ld_valid),
    .ld_addr  (ld_addr),
    .ld_data  (ld_data),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data)
);

// File: tb/test_swz_lane_adder.sv
module test_swz_lane_adder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [4:0]  op_src0 = '0;
    logic [4:0]  op_src1 = '0;
    logic [7:0]  op_swz0 = '0;
    logic [7:0]  op_swz1 = '0;
    logic [4:0]  op_dst = '0;
    logic [3:0]  op_mask = '0;
    logic        ld_valid = 1'b0;
    logic [4:0]  ld_addr = '0;
    logic [95:0] ld_data = '0;
    logic [4:0]  rd_addr = '0;
    logic [95:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    swz_lane_adder i_swz_lane_adder (.*);

    localparam logic [95:0] FILL = 96'hAAAAAA_AAAAAA_AAAAAA_AAAAAA;
    // {swz0, swz1, mask, expected destination}
    localparam logic [115:0] VEC [5] = '{
        {8'h44, 8'h05, 4'b0011, 96'hAAAAAA_AAAAAA_000022_000021},
        {8'hE4, 8'hE4, 4'b1111, 96'h000044_000033_000022_000011},
        {8'hFF, 8'h00, 4'b1010, 96'h000014_AAAAAA_000014_AAAAAA},
        {8'h1B, 8'hAA, 4'b0100, 96'hAAAAAA_000032_AAAAAA_AAAAAA},
        {8'hE4, 8'hE4, 4'b0000, FILL}
    };
    localparam string VTAG [5] = '{"R3", "R4", "R3", "R5", "R6"};

    task automatic do_load(input logic [4:0] a, input logic [95:0] d);
        @(negedge clk);
        ld_valid = 1'b1; ld_addr = a; ld_data = d;
        @(negedge clk);
        ld_valid = 1'b0;
    endtask

    task automatic set_op(input logic [4:0] d, input logic [4:0] s0, input logic [4:0] s1,
                          input logic [7:0] z0, input logic [7:0] z1, input logic [3:0] m);
        op_dst = d; op_src0 = s0; op_src1 = s1; op_swz0 = z0; op_swz1 = z1; op_mask = m;
    endtask

    task automatic do_add(input logic [4:0] d, input logic [4:0] s0, input logic [4:0] s1,
                          input logic [7:0] z0, input logic [7:0] z1, input logic [3:0] m);
        @(negedge clk);
        set_op(d, s0, s1, z0, z1, m);
        op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic expect_reg(input logic [4:0] a, input logic [95:0] exp, input string tag);
        rd_addr = a;
        #1;
        checks++;
        if (rd_data !== exp) begin
            errors++;
            $display("FAIL %s reg %0d got %h expected %h", tag, a, rd_data, exp);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        expect_reg(5'd0, '0, "R1");
        expect_reg(5'd31, '0, "R1");

        do_load(5'd1, 96'h000004_000003_000002_000001);
        do_load(5'd2, 96'h000040_000030_000020_000010);
        expect_reg(5'd1, 96'h000004_000003_000002_000001, "R2");

        // Table walk: refill R3, add R1,R2 into it, check the result.
        for (int v = 0; v < 5; v++) begin
            do_load(5'd3, FILL);
            do_add(5'd3, 5'd1, 5'd2, VEC[v][115:108], VEC[v][107:100], VEC[v][99:96]);
            expect_reg(5'd3, VEC[v][95:0], VTAG[v]);
        end

        // R4: wraparound in each lane, no carry into the neighbour.
        do_load(5'd4, 96'h7FFFFF_000001_800000_FFFFFF);
        do_load(5'd5, 96'h000001_FFFFFF_800000_000001);
        do_add(5'd10, 5'd4, 5'd5, 8'hE4, 8'hE4, 4'hF);
        expect_reg(5'd10, 96'h800000_000000_000000_000000, "R4");

        // R7: destination is also both sources.
        do_load(5'd6, 96'h000008_000007_000006_000005);
        do_add(5'd6, 5'd6, 5'd6, 8'hE4, 8'h1B, 4'hF);
        expect_reg(5'd6, 96'h00000D_00000D_00000D_00000D, "R7");

        // R8: add and load on the same register; the load is dropped.
        do_load(5'd7, 96'h000001_000001_000001_000001);
        @(negedge clk);
        set_op(5'd7, 5'd1, 5'd2, 8'hE4, 8'hE4, 4'b0001);
        op_valid = 1'b1;
        ld_valid = 1'b1; ld_addr = 5'd7; ld_data = 96'hFFFFFF_FFFFFF_FFFFFF_FFFFFF;
        @(negedge clk);
        op_valid = 1'b0; ld_valid = 1'b0;
        expect_reg(5'd7, 96'h000001_000001_000001_000011, "R8");

        // R8: a load to a different register in the same cycle completes.
        @(negedge clk);
        set_op(5'd8, 5'd1, 5'd2, 8'hE4, 8'hE4, 4'hF);
        op_valid = 1'b1;
        ld_valid = 1'b1; ld_addr = 5'd9; ld_data = 96'h123456_654321_0ABCDE_EDCBA0;
        @(negedge clk);
        op_valid = 1'b0; ld_valid = 1'b0;
        expect_reg(5'd8, 96'h000044_000033_000022_000011, "R8");
        expect_reg(5'd9, 96'h123456_654321_0ABCDE_EDCBA0, "R8");

        // R9: add inputs without op_valid change nothing.
        do_load(5'd3, FILL);
        @(negedge clk);
        set_op(5'd3, 5'd1, 5'd2, 8'hE4, 8'hE4, 4'hF);
        repeat (2) @(negedge clk);
        expect_reg(5'd3, FILL, "R9");

        // R10: read port follows rd_addr with no clock edge.
        @(negedge clk);
        expect_reg(5'd2, 96'h000040_000030_000020_000010, "R10");
        expect_reg(5'd9, 96'h123456_654321_0ABCDE_EDCBA0, "R10");

        // R1: reset mid-run clears loaded registers.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        expect_reg(5'd1, '0, "R1");
        expect_reg(5'd9, '0, "R1");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule